// File: doc/BRIEF.md
# Burst ROM Read Access Sequencer

This block drives an external memory bus for a CPU. The upper address bits pick the area. Two of the areas, region 0 and region 1, can each be set up as burst-capable ROM. A CPU read to an enabled region first runs a full-length access. After that, chip select and the read strobe stay low. If the CPU presents the next sequential word in the cycle where `cpu_ready` is high, that word is fetched with a short burst cycle of fixed length. The address steps only inside the aligned block of the programmed burst length.

Each region has its own configuration inputs:
- burst enable
- 2-bit burst length code
- 3-bit burst cycle length
- full-access base length (2 or 3 states)
- 0 to 7 programmed waits

Writes, reads issued on behalf of a non-CPU master, and all traffic to the other areas run as plain single accesses. The external wait input stretches full accesses only.

Top module: `brom_seq`

## Requirements
- R1: `cpu_addr[15:14]` selects the area: 00 is region 0, 01 is region 1, 10 and 11 are the other area. The other area always runs single accesses of 2 + OTHER_WAITS states (3 by default) and honours `mem_wait`.
- R2: A full access lasts (`cfg_init_long` ? 3 : 2) + `cfg_init_wait` states of the addressed region. During those states `mem_cs_n` is low, `mem_addr` equals the request address, and `mem_rd_n` is low for a read. Each cycle that `mem_wait` is high in the last state adds one state.
- R3: Read data is captured in the last state. In the next cycle `cpu_ready` is high for exactly one cycle and `cpu_rdata` holds the word.
- R4: After a full CPU read to a region whose burst enable is 1, chip select and the read strobe stay low in the ready cycle. A request in that cycle for the sequential address is served as a burst cycle.
- R5: A burst cycle lasts `cfg_burst_cyc` + 1 states (field 0..7 gives 1..8 states) of the region that opened the burst. `mem_wait` has no effect on its length.
- R6: Burst length code 0, 1, 2, 3 allows 4, 8, 16, 32 words, counting the full access. A request beyond that count gets a full access that starts a new burst.
- R7: The sequential address increments only the low log2(words) bits and wraps inside the aligned block. Upper bits are unchanged, so leaving the block forces a full access.
- R8: With no request in the ready cycle, chip select goes high in the next cycle, and a later request gets a full access. A non-sequential request in the ready cycle also gets a full access.
- R9: A write (`cpu_rd`=0) or a non-CPU read (`cpu_master`=0) is a single access, even in an enabled region. A write drives `mem_wr_n` low, keeps `mem_rd_n` high and presents `cpu_wdata` on `mem_wdata`. Chip select is high after it.
- R10: Regions are independent. Each access uses only its own region's enable, length, burst cycle and full-access fields, where region r uses `cfg_burst_len[2r+1:2r]`, `cfg_burst_cyc[3r+2:3r]` and `cfg_init_wait[3r+2:3r]`.
- R11: Synchronous active-high reset leaves `mem_cs_n`, `mem_rd_n` and `mem_wr_n` high and `cpu_ready` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one bus state per cycle |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Request, held until `cpu_ready` is seen |
| cpu_rd | input | 1 | 1 = read, 0 = write |
| cpu_master | input | 1 | 1 = issued by the CPU, 0 = other master |
| cpu_addr | input | AW | Word address |
| cpu_wdata | input | DW | Write data |
| cpu_rdata | output | DW | Read data |
| cpu_ready | output | 1 | One-cycle completion pulse |
| cfg_burst_en | input | 2 | Burst enable per region |
| cfg_burst_len | input | 4 | Burst length code, 2 bits per region |
| cfg_burst_cyc | input | 6 | Burst cycle states minus one, 3 bits per region |
| cfg_init_long | input | 2 | Full access base: 0 = 2 states, 1 = 3 states |
| cfg_init_wait | input | 6 | Programmed waits, 3 bits per region |
| mem_addr | output | AW | External address |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_rd_n | output | 1 | Read strobe, active low |
| mem_wr_n | output | 1 | Write strobe, active low |
| mem_wdata | output | DW | External write data |
| mem_rdata | input | DW | External read data |
| mem_wait | input | 1 | External wait request |

## Verification
A request is sampled at the edge that ends its first cycle. The access states then follow in the next N cycles, and `cpu_ready` with data is due one cycle after the last state. N is the full-access length plus any sampled `mem_wait` cycles, or the burst cycle length with `mem_wait` ignored. The bench derives N from the configuration for every request and builds the expected bus and CPU outputs for each cycle. It compares them at the falling edge of every clock, so a missing or extra state shows up in the exact cycle it happens. The next request is driven in the ready cycle itself, which exercises the burst continuation window and the idle gap that ends a burst.

// File: rtl/brom_pkg.sv
`timescale 1ns/1ps
package brom_pkg;

    localparam int unsigned BLEN_W     = 2;
    localparam int unsigned BCYC_W     = 3;
    localparam int unsigned IWAIT_W    = 3;
    localparam int unsigned MAX_STATES = 3 + (2**IWAIT_W - 1);
    localparam int unsigned CNT_W      = $clog2(MAX_STATES);
    localparam int unsigned MAX_WORDS  = 4 << (2**BLEN_W - 1);
    localparam int unsigned WRAP_W     = $clog2(MAX_WORDS);
    localparam int unsigned BEAT_W     = $clog2(MAX_WORDS + 1);

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_INIT  = 2'd1,
        ST_BURST = 2'd2,
        ST_HOLD  = 2'd3
    } seq_state_e;

    typedef struct packed {
        logic               burst_en;
        logic [BLEN_W-1:0]  blen;
        logic [BCYC_W-1:0]  bcyc;
        logic               init_long;
        logic [IWAIT_W-1:0] iwait;
    } region_cfg_t;

    // Timer load for a full access: state count minus one.
    function automatic logic [CNT_W-1:0] init_load(region_cfg_t c);
        return CNT_W'(c.init_long ? 2 : 1) + CNT_W'(c.iwait);
    endfunction

    function automatic logic [BEAT_W-1:0] burst_words(logic [BLEN_W-1:0] code);
        return BEAT_W'(4) << code;
    endfunction

    function automatic logic [WRAP_W-1:0] wrap_mask(logic [BLEN_W-1:0] code);
        logic [BEAT_W-1:0] w;
        w = burst_words(code) - BEAT_W'(1);
        return w[WRAP_W-1:0];
    endfunction

endpackage

// File: rtl/brom_region_dec.sv
`timescale 1ns/1ps
module brom_region_dec
    import brom_pkg::*;
#(
    parameter int unsigned NREG        = 2,
    parameter int unsigned OTHER_WAITS = 1,
    localparam int unsigned SELW       = $clog2(NREG) + 1
) (
    input  logic [SELW-1:0]         sel_bits,
    input  region_cfg_t [NREG-1:0]  cfg_arr,
    output region_cfg_t             sel_cfg,
    output logic                    burst_area
);

    localparam region_cfg_t OTHER_CFG = '{
        burst_en:  1'b0,
        blen:      '0,
        bcyc:      '0,
        init_long: 1'b0,
        iwait:     IWAIT_W'(OTHER_WAITS)
    };

    logic [NREG-1:0] match;

    for (genvar g = 0; g < NREG; g++) begin : g_match
        assign match[g] = (sel_bits == SELW'(g));
    end

    always_comb begin
        sel_cfg    = OTHER_CFG;
        burst_area = 1'b0;
        for (int i = 0; i < NREG; i++) begin
            if (match[i]) begin
                sel_cfg    = cfg_arr[i];
                burst_area = 1'b1;
            end
        end
    end

endmodule

// File: rtl/brom_addr_step.sv
`timescale 1ns/1ps
module brom_addr_step
    import brom_pkg::*;
#(
    parameter int unsigned AW = 16
) (
    input  logic [AW-1:0]     base,
    input  logic [BLEN_W-1:0] len_code,
    output logic [AW-1:0]     next
);

    logic [WRAP_W-1:0] low, inc, msk, nlow;

    always_comb begin
        low  = base[WRAP_W-1:0];
        inc  = low + WRAP_W'(1);
        msk  = wrap_mask(len_code);
        nlow = (low & ~msk) | (inc & msk);
        next = {base[AW-1:WRAP_W], nlow};
    end

endmodule

// File: rtl/brom_cycle_timer.sv
`timescale 1ns/1ps
module brom_cycle_timer #(
    parameter int unsigned CW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          run,
    input  logic          wait_en,
    input  logic          ext_wait,
    output logic          done,
    output logic [CW-1:0] remain
);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (run && cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign done   = run && (cnt == '0) && !(wait_en && ext_wait);
    assign remain = cnt;

    // R5: outside wait-capable cycles the count falls every state, wait or not
    a_r5_no_stretch: assert property (@(posedge clk) disable iff (rst)
        (run && !wait_en && !load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

endmodule

// File: rtl/brom_seq.sv
`timescale 1ns/1ps
module brom_seq
    import brom_pkg::*;
#(
    parameter int unsigned AW          = 16,
    parameter int unsigned DW          = 16,
    parameter int unsigned NREG        = 2,
    parameter int unsigned OTHER_WAITS = 1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     cpu_req,
    input  logic                     cpu_rd,
    input  logic                     cpu_master,
    input  logic [AW-1:0]            cpu_addr,
    input  logic [DW-1:0]            cpu_wdata,
    output logic [DW-1:0]            cpu_rdata,
    output logic                     cpu_ready,
    input  logic [NREG-1:0]          cfg_burst_en,
    input  logic [NREG*BLEN_W-1:0]   cfg_burst_len,
    input  logic [NREG*BCYC_W-1:0]   cfg_burst_cyc,
    input  logic [NREG-1:0]          cfg_init_long,
    input  logic [NREG*IWAIT_W-1:0]  cfg_init_wait,
    output logic [AW-1:0]            mem_addr,
    output logic                     mem_cs_n,
    output logic                     mem_rd_n,
    output logic                     mem_wr_n,
    output logic [DW-1:0]            mem_wdata,
    input  logic [DW-1:0]            mem_rdata,
    input  logic                     mem_wait
);

    localparam int unsigned SELW = $clog2(NREG) + 1;

    region_cfg_t [NREG-1:0] cfg_arr;

    for (genvar g = 0; g < NREG; g++) begin : g_cfg
        assign cfg_arr[g] = '{
            burst_en:  cfg_burst_en[g],
            blen:      cfg_burst_len[g*BLEN_W +: BLEN_W],
            bcyc:      cfg_burst_cyc[g*BCYC_W +: BCYC_W],
            init_long: cfg_init_long[g],
            iwait:     cfg_init_wait[g*IWAIT_W +: IWAIT_W]
        };
    end

    seq_state_e         st;
    logic [AW-1:0]      acc_addr;
    logic               acc_rd;
    logic               acc_burst;
    logic [BLEN_W-1:0]  acc_blen;
    logic [BCYC_W-1:0]  acc_bcyc;
    logic [BEAT_W-1:0]  beats;
    logic [DW-1:0]      wdata_q;
    logic [DW-1:0]      rdata_q;
    logic               ready_q;

    region_cfg_t        sel_cfg;
    logic               burst_area;
    logic [AW-1:0]      next_addr;
    logic               accept, seq_hit;
    logic               tmr_run, tmr_wait_en, tmr_done;
    logic [CNT_W-1:0]   tmr_val, tmr_remain;

    brom_region_dec #(
        .NREG        (NREG),
        .OTHER_WAITS (OTHER_WAITS)
    ) u_dec (
        .sel_bits   (cpu_addr[AW-1 -: SELW]),
        .cfg_arr    (cfg_arr),
        .sel_cfg    (sel_cfg),
        .burst_area (burst_area)
    );

    brom_addr_step #(.AW(AW)) u_step (
        .base     (acc_addr),
        .len_code (acc_blen),
        .next     (next_addr)
    );

    assign accept  = cpu_req && (st == ST_IDLE || st == ST_HOLD);
    assign seq_hit = (st == ST_HOLD) && cpu_rd && cpu_master
                     && (cpu_addr == next_addr)
                     && (beats < burst_words(acc_blen));

    assign tmr_run     = (st == ST_INIT) || (st == ST_BURST);
    assign tmr_wait_en = (st == ST_INIT);
    assign tmr_val     = seq_hit ? CNT_W'(acc_bcyc) : init_load(sel_cfg);

    brom_cycle_timer #(.CW(CNT_W)) u_tmr (
        .clk      (clk),
        .rst      (rst),
        .load     (accept),
        .load_val (tmr_val),
        .run      (tmr_run),
        .wait_en  (tmr_wait_en),
        .ext_wait (mem_wait),
        .done     (tmr_done),
        .remain   (tmr_remain)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            acc_addr  <= '0;
            acc_rd    <= 1'b0;
            acc_burst <= 1'b0;
            acc_blen  <= '0;
            acc_bcyc  <= '0;
            beats     <= '0;
            wdata_q   <= '0;
            rdata_q   <= '0;
            ready_q   <= 1'b0;
        end else begin
            ready_q <= 1'b0;
            unique case (st)
                ST_IDLE, ST_HOLD: begin
                    if (accept && seq_hit) begin
                        st       <= ST_BURST;
                        acc_addr <= cpu_addr;
                        beats    <= beats + BEAT_W'(1);
                    end else if (accept) begin
                        st        <= ST_INIT;
                        acc_addr  <= cpu_addr;
                        acc_rd    <= cpu_rd;
                        acc_burst <= burst_area && sel_cfg.burst_en
                                     && cpu_rd && cpu_master;
                        acc_blen  <= sel_cfg.blen;
                        acc_bcyc  <= sel_cfg.bcyc;
                        beats     <= BEAT_W'(1);
                        wdata_q   <= cpu_wdata;
                    end else begin
                        st <= ST_IDLE;
                    end
                end
                ST_INIT, ST_BURST: begin
                    if (tmr_done) begin
                        ready_q <= 1'b1;
                        if (acc_rd) rdata_q <= mem_rdata;
                        st <= acc_burst ? ST_HOLD : ST_IDLE;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign mem_addr  = acc_addr;
    assign mem_wdata = wdata_q;
    assign mem_cs_n  = (st == ST_IDLE);
    assign mem_rd_n  = !((st != ST_IDLE) && acc_rd);
    assign mem_wr_n  = !((st == ST_INIT) && !acc_rd);
    assign cpu_rdata = rdata_q;
    assign cpu_ready = ready_q;

    // Checker state: states spent in the current burst cycle
    logic [CNT_W-1:0] bctr;
    always_ff @(posedge clk) begin
        if (rst)                bctr <= '0;
        else if (st == ST_BURST) bctr <= bctr + 1'b1;
        else                    bctr <= '0;
    end

    // R2: external wait in the last full-access state holds the access open
    a_r2_wait_extends: assert property (@(posedge clk) disable iff (rst)
        (st == ST_INIT && tmr_remain == '0 && mem_wait) |=> (st == ST_INIT && !cpu_ready));

    // R3: ready is a single-cycle pulse
    a_r3_ready_pulse: assert property (@(posedge clk) disable iff (rst)
        cpu_ready |=> !cpu_ready);

    // R5: a burst cycle spends exactly the configured number of states
    a_r5_burst_len: assert property (@(posedge clk) disable iff (rst)
        ($past(st) == ST_BURST && st != ST_BURST) |-> ($past(bctr) == CNT_W'(acc_bcyc)));

    // R6: never more words than the burst length allows
    a_r6_word_limit: assert property (@(posedge clk) disable iff (rst)
        (st == ST_BURST) |-> (beats <= burst_words(acc_blen)));

    // R7: a burst step keeps the address bits above the block
    a_r7_block_kept: assert property (@(posedge clk) disable iff (rst)
        ($past(st) == ST_HOLD && st == ST_BURST)
        |-> (((acc_addr ^ $past(acc_addr)) & ~AW'(wrap_mask(acc_blen))) == '0));

    // R8: a gap in the ready cycle releases chip select
    a_r8_gap_release: assert property (@(posedge clk) disable iff (rst)
        (st == ST_HOLD && !cpu_req) |=> mem_cs_n);

    // R9: an accepted write always starts a full single access
    a_r9_write_single: assert property (@(posedge clk) disable iff (rst)
        (cpu_req && !cpu_rd && (st == ST_IDLE || st == ST_HOLD)) |=> (st == ST_INIT));

endmodule

// File: tb/brom_seq_bench.sv
`timescale 1ns/1ps
module brom_seq_bench;

    localparam int OW = 1;

    logic        clk = 1'b0;
    logic        rst;
    logic        cpu_req, cpu_rd, cpu_master;
    logic [15:0] cpu_addr, cpu_wdata;
    logic [15:0] cpu_rdata;
    logic        cpu_ready;
    logic [15:0] mem_addr, mem_wdata, mem_rdata;
    logic        mem_cs_n, mem_rd_n, mem_wr_n;
    logic        mem_wait;

    logic [1:0]  en, lng;
    logic [1:0]  lenc [2];
    logic [2:0]  cyc  [2];
    logic [2:0]  iw   [2];

    int n_checks = 0;
    int n_err    = 0;
    int cyc_cnt  = 0;

    // bench model of the open burst
    bit          open = 1'b0;
    logic [15:0] last_a = '0;
    int          words = 0, cur_words = 4, cur_cyc = 1;

    always #2.5 clk = ~clk;

    function automatic logic [15:0] rom_word(input logic [15:0] a);
        return {a[7:0] ^ 8'h3C, a[15:8] ^ 8'hA5};
    endfunction

    assign mem_rdata = rom_word(mem_addr);

    brom_seq #(.AW(16), .DW(16), .NREG(2), .OTHER_WAITS(OW)) u_brom_seq (
        .clk           (clk),
        .rst           (rst),
        .cpu_req       (cpu_req),
        .cpu_rd        (cpu_rd),
        .cpu_master    (cpu_master),
        .cpu_addr      (cpu_addr),
        .cpu_wdata     (cpu_wdata),
        .cpu_rdata     (cpu_rdata),
        .cpu_ready     (cpu_ready),
        .cfg_burst_en  (en),
        .cfg_burst_len ({lenc[1], lenc[0]}),
        .cfg_burst_cyc ({cyc[1], cyc[0]}),
        .cfg_init_long (lng),
        .cfg_init_wait ({iw[1], iw[0]}),
        .mem_addr      (mem_addr),
        .mem_cs_n      (mem_cs_n),
        .mem_rd_n      (mem_rd_n),
        .mem_wr_n      (mem_wr_n),
        .mem_wdata     (mem_wdata),
        .mem_rdata     (mem_rdata),
        .mem_wait      (mem_wait)
    );

    always @(posedge clk) begin
        cyc_cnt++;
        if (cyc_cnt == 150000) begin
            n_err++;
            $display("FAIL watchdog: run still active after %0d cycles, expected completion", cyc_cnt);
            $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_err);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic e_cs, input logic e_rd, input logic e_wr,
                       input bit use_a, input logic [15:0] e_a, input logic e_rdy,
                       input bit use_d, input logic [15:0] e_d,
                       input bit use_w, input logic [15:0] e_w);
        bit bad;
        n_checks++;
        bad = (mem_cs_n !== e_cs) || (mem_rd_n !== e_rd) || (mem_wr_n !== e_wr)
              || (cpu_ready !== e_rdy)
              || (use_a && (mem_addr !== e_a))
              || (use_d && (cpu_rdata !== e_d))
              || (use_w && (mem_wdata !== e_w));
        if (bad) begin
            n_err++;
            $display("FAIL %s t=%0t: got cs_n=%b rd_n=%b wr_n=%b addr=%h ready=%b rdata=%h wdata=%h, expected cs_n=%b rd_n=%b wr_n=%b addr=%h ready=%b rdata=%h wdata=%h",
                     tag, $time, mem_cs_n, mem_rd_n, mem_wr_n, mem_addr, cpu_ready, cpu_rdata,
                     mem_wdata, e_cs, e_rd, e_wr, e_a, e_rdy, e_d, e_w);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    // One request, issued now; expected outputs checked on every following cycle.
    task automatic access(input string tag, input logic [15:0] a, input logic rd,
                          input logic master, input logic [15:0] wd, input int ext);
        bit          hit;
        int          n, total, r;
        logic [15:0] msk, nx;
        msk = 16'(cur_words - 1);
        nx  = (last_a & ~msk) | ((last_a + 16'd1) & msk);
        hit = open && (rd == 1'b1) && (master == 1'b1) && (a == nx) && (words < cur_words);
        r   = int'(a[15:14]);
        if (hit) begin
            n     = cur_cyc;
            total = n;
            words++;
        end else begin
            n     = (r >= 2) ? (2 + OW) : ((lng[r] ? 3 : 2) + int'(iw[r]));
            total = n + ext;
            words = 1;
            open  = (rd == 1'b1) && (master == 1'b1) && (r < 2) && (r < 2 ? en[r] == 1'b1 : 1'b0);
            if (r < 2) begin
                cur_words = 4 << lenc[r];
                cur_cyc   = int'(cyc[r]) + 1;
            end
        end
        last_a     = a;
        cpu_req    = 1'b1;
        cpu_addr   = a;
        cpu_rd     = rd;
        cpu_master = master;
        cpu_wdata  = wd;
        mem_wait   = hit && (ext > 0);
        for (int s = 1; s <= total; s++) begin
            step();
            chk(tag, 1'b0, !rd, rd, 1'b1, a, 1'b0, 1'b0, '0, !rd, wd);
            if (!hit) mem_wait = (s >= n) && (s < total);
        end
        step();
        chk(tag, !open, !open, 1'b1, open, a, 1'b1, rd, rom_word(a), 1'b0, '0);
        cpu_req  = 1'b0;
        mem_wait = 1'b0;
    endtask

    task automatic idle_cycles(input string tag, input int n);
        cpu_req = 1'b0;
        for (int i = 0; i < n; i++) begin
            step();
            chk(tag, 1'b1, 1'b1, 1'b1, 1'b0, '0, 1'b0, 1'b0, '0, 1'b0, '0);
        end
        open = 1'b0;
    endtask

    initial begin
        rst = 1'b1; cpu_req = 1'b0; cpu_rd = 1'b1; cpu_master = 1'b1;
        cpu_addr = '0; cpu_wdata = '0; mem_wait = 1'b0;
        en = 2'b00; lng = 2'b00;
        for (int i = 0; i < 2; i++) begin lenc[i] = '0; cyc[i] = '0; iw[i] = '0; end
        repeat (3) @(negedge clk);
        // R11: reset state
        chk("R11", 1'b1, 1'b1, 1'b1, 1'b0, '0, 1'b0, 1'b0, '0, 1'b0, '0);
        rst = 1'b0;
        idle_cycles("R11", 2);

        // R2 R3: short full access, then long one stretched by external wait
        access("R3", 16'h0010, 1'b1, 1'b1, '0, 0);
        idle_cycles("R2", 1);
        lng[0] = 1'b1; iw[0] = 3'd3;
        access("R2", 16'h0011, 1'b1, 1'b1, '0, 2);
        idle_cycles("R2", 1);

        // R4 R5 R6 R7: region 0, 4-word bursts of 3 states
        en[0] = 1'b1; lenc[0] = 2'd0; cyc[0] = 3'd2;
        access("R4", 16'h0105, 1'b1, 1'b1, '0, 0);
        access("R5", 16'h0106, 1'b1, 1'b1, '0, 2);
        access("R7", 16'h0107, 1'b1, 1'b1, '0, 0);
        access("R7", 16'h0104, 1'b1, 1'b1, '0, 0);
        access("R6", 16'h0105, 1'b1, 1'b1, '0, 0);
        access("R4", 16'h0106, 1'b1, 1'b1, '0, 0);
        access("R4", 16'h0107, 1'b1, 1'b1, '0, 0);
        access("R7", 16'h0108, 1'b1, 1'b1, '0, 0);
        idle_cycles("R8", 2);

        // R8: region 1, 8-word bursts of 1 state; non-sequential and gap cases
        en[1] = 1'b1; lenc[1] = 2'd1; cyc[1] = 3'd0; lng[1] = 1'b0; iw[1] = 3'd1;
        access("R4", 16'h4003, 1'b1, 1'b1, '0, 0);
        access("R5", 16'h4004, 1'b1, 1'b1, '0, 1);
        access("R5", 16'h4005, 1'b1, 1'b1, '0, 0);
        access("R8", 16'h4010, 1'b1, 1'b1, '0, 0);
        idle_cycles("R8", 1);
        access("R8", 16'h4011, 1'b1, 1'b1, '0, 0);

        // R10: alternate regions, each with its own timing
        access("R10", 16'h0200, 1'b1, 1'b1, '0, 0);
        access("R10", 16'h0201, 1'b1, 1'b1, '0, 0);
        access("R10", 16'h4100, 1'b1, 1'b1, '0, 0);
        access("R10", 16'h4101, 1'b1, 1'b1, '0, 0);

        // R9: write, then non-CPU read, inside enabled region 1
        access("R9", 16'h4102, 1'b0, 1'b1, 16'hBEEF, 0);
        access("R9", 16'h4103, 1'b1, 1'b1, '0, 0);
        access("R9", 16'h4104, 1'b1, 1'b0, '0, 0);
        access("R9", 16'h4105, 1'b1, 1'b1, '0, 0);
        idle_cycles("R9", 1);
        access("R9", 16'h0300, 1'b0, 1'b1, 16'h1234, 1);
        idle_cycles("R9", 1);

        // R1: other area, honours external wait, never bursts
        access("R1", 16'h8001, 1'b1, 1'b1, '0, 1);
        access("R1", 16'h8002, 1'b1, 1'b1, '0, 0);
        access("R1", 16'hC003, 1'b0, 1'b1, 16'h5AA5, 0);
        idle_cycles("R1", 1);

        // R6 R7: 32-word burst wrapping in its block, then full access
        lenc[0] = 2'd3; cyc[0] = 3'd0;
        access("R6", 16'h0310, 1'b1, 1'b1, '0, 0);
        for (int k = 1; k < 32; k++)
            access("R7", 16'h0300 | 16'((16 + k) % 32), 1'b1, 1'b1, '0, 0);
        access("R6", 16'h0310, 1'b1, 1'b1, '0, 0);
        idle_cycles("R8", 1);

        // R6: 16-word burst of 8-state cycles in region 1
        lenc[1] = 2'd2; cyc[1] = 3'd7;
        access("R6", 16'h4027, 1'b1, 1'b1, '0, 0);
        for (int k = 1; k < 16; k++)
            access("R5", 16'h4020 | 16'((7 + k) % 16), 1'b1, 1'b1, '0, (k % 3 == 0) ? 1 : 0);
        access("R6", 16'h4027, 1'b1, 1'b1, '0, 0);
        idle_cycles("R8", 2);

        $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

endmodule